// File: doc/BRIEF.md
# Two-Button Guarded Reset Sequencer

This block turns two debounced push-button levels into a deliberate reset request. One button is the guard and the other is the action. A reset request is raised only when the action button goes down while the guard button is already being held. A single press of either button on its own never resets anything.

The block registers both button levels once and derives press and release edges from them. A three-state controller (idle, armed, fired) consumes these edges. The controller hands a fire strobe to the datapath, which shapes it into a one-clock reset request. After one reset, the controller stays inert until the guard button is let go. Holding the guard and tapping the action button repeatedly therefore yields exactly one reset per hold.

The current state is brought out so that a system controller or a test can observe it.

Top module: `guard_reset_seq`

## Requirements
- R1: After the asynchronous active-low reset, `stateOut` reads idle and `resetReq` is low. The state encoding is idle = 0, armed = 1 and fired = 2, and the code 3 never appears.
- R2: A press is a button level that is 1 at a rising clock edge after having been 0 at the previous edge. A release is the reverse. The stored previous levels clear to 0 on reset, so a button held through reset counts as pressed at the first edge after reset.
- R3: In idle, a guard press moves the state to armed at that edge. Every other event in idle, including an action press, leaves the state idle and produces no reset request.
- R4: In armed, a guard release returns the state to idle. Events other than a guard release or an action press leave the state armed.
- R5: In armed, an action press that comes without a guard release moves the state to fired. It also drives `resetReq` high for exactly one clock, in the same cycle in which `stateOut` first shows fired.
- R6: In armed, if a guard release and an action press occur at the same edge, the release wins. The state returns to idle and no reset request is produced.
- R7: In fired, only a guard release has any effect, and it returns the state to idle. Action presses and releases leave the state fired and produce no reset request.
- R8: At most one reset request is produced between a guard press and the following guard release, however many times the action button is pressed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| guardBtn | input | 1 | Debounced guard button level, 1 = held |
| actionBtn | input | 1 | Debounced action button level, 1 = held |
| resetReq | output | 1 | One-clock reset request pulse |
| stateOut | output | 2 | Current controller state (0 idle, 1 armed, 2 fired) |

## Verification
The hardest situation to reach from the ports is an edge collision in armed: a guard release and an action press land on the same clock edge (R6). The fired state with repeated action presses (R7, R8) is also hard to reach. Neither happens unless a specific history of levels has been set up first.

The bench reaches these situations by sweeping every sequence of five consecutive (guard, action) level pairs after reset, which is 1024 sequences. An arithmetic reference model tracks the previous levels and the expected state and pulse. A short directed run holds the guard button through reset, to cover the cleared previous-level rule.

// File: rtl/grs_pkg.sv
package grs_pkg;
  localparam int BTN_COUNT  = 2;
  localparam int GUARD_IDX  = 0;
  localparam int ACTION_IDX = 1;
  localparam int STATE_W    = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_FIRED = 2'd2
  } seqState_t;

  // Edge strobes from datapath to control
  typedef struct packed {
    logic [BTN_COUNT-1:0] rise;
    logic [BTN_COUNT-1:0] fall;
  } btnEdges_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic fire;
  } ctrlStrobes_t;
endpackage

// File: rtl/grs_datapath.sv
module grs_datapath
  import grs_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BTN_COUNT-1:0] levels,
  input  ctrlStrobes_t         strobes,
  output btnEdges_t            edges,
  output logic                 resetReq
);
  logic [BTN_COUNT-1:0] prevLevel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevLevel <= '0;
    else       prevLevel <= levels;
  end

  for (genvar i = 0; i < BTN_COUNT; i++) begin : g_edge
    assign edges.rise[i] = levels[i] & ~prevLevel[i];
    assign edges.fall[i] = ~levels[i] & prevLevel[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resetReq <= 1'b0;
    else       resetReq <= strobes.fire;
  end

  // R5: the request never lasts more than one clock
  p_pulse_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |=> !resetReq);
endmodule

// File: rtl/grs_control.sv
module grs_control
  import grs_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  btnEdges_t    edges,
  output ctrlStrobes_t strobes,
  output seqState_t    state
);
  seqState_t nextState;
  logic guardPress, guardRelease, actionPress;

  assign guardPress   = edges.rise[GUARD_IDX];
  assign guardRelease = edges.fall[GUARD_IDX];
  assign actionPress  = edges.rise[ACTION_IDX];

  always_comb begin
    nextState    = state;
    strobes.fire = 1'b0;
    case (state)
      ST_IDLE:  if (guardPress) nextState = ST_ARMED;
      ST_ARMED: begin
        if (guardRelease) nextState = ST_IDLE;
        else if (actionPress) begin
          nextState    = ST_FIRED;
          strobes.fire = 1'b1;
        end
      end
      ST_FIRED: if (guardRelease) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  p_state_legal_r1: assert property (@(posedge clk) disable iff (!rstN)
    state != 2'd3);
  p_idle_never_fires_r3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) |=> (state != ST_FIRED));
  p_release_wins_r6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ARMED && guardRelease) |=> (state == ST_IDLE));
  p_fired_exit_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIRED) |=> (state != ST_ARMED));
  p_no_refire_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_FIRED) |-> !strobes.fire);
endmodule

// File: rtl/guard_reset_seq.sv
module guard_reset_seq
  import grs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               guardBtn,
  input  logic               actionBtn,
  output logic               resetReq,
  output logic [STATE_W-1:0] stateOut
);
  logic [BTN_COUNT-1:0] levels;
  btnEdges_t    edges;
  ctrlStrobes_t strobes;
  seqState_t    state;

  always_comb begin
    levels             = '0;
    levels[GUARD_IDX]  = guardBtn;
    levels[ACTION_IDX] = actionBtn;
  end

  grs_datapath u_datapath (
    .clk(clk), .rstN(rstN), .levels(levels), .strobes(strobes),
    .edges(edges), .resetReq(resetReq)
  );

  grs_control u_control (
    .clk(clk), .rstN(rstN), .edges(edges), .strobes(strobes), .state(state)
  );

  assign stateOut = state;

  // R5: a request coincides with the first cycle of fired, entered from armed
  p_pulse_enters_fired_r5: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> (stateOut == 2'd2 && $past(stateOut) == 2'd1));
endmodule

// File: tb/guard_reset_seq_tb.sv
module guard_reset_seq_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic guardBtn = 1'b0;
  logic actionBtn = 1'b0;
  logic resetReq;
  logic [1:0] stateOut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int mState;
  bit mPrevG, mPrevA;

  always #2 clk = ~clk;

  guard_reset_seq u_dut (
    .clk(clk), .rstN(rstN), .guardBtn(guardBtn), .actionBtn(actionBtn),
    .resetReq(resetReq), .stateOut(stateOut)
  );

  task automatic compare(input string tag, input int expState, input bit expPulse);
    checks++;
    if (stateOut !== expState[1:0] || resetReq !== expPulse) begin
      fails++;
      $display("FAIL %s: state actual=%0d expected=%0d pulse actual=%0b expected=%0b",
               tag, stateOut, expState, resetReq, expPulse);
    end
  endtask

  task automatic applyReset(input bit g, input bit a);
    @(negedge clk);
    rstN = 1'b0; guardBtn = g; actionBtn = a;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mState = 0; mPrevG = 1'b0; mPrevA = 1'b0;
    compare("R1", 0, 1'b0);
  endtask

  task automatic step(input bit g, input bit a, output bit pulse);
    bit gP, gR, aP;
    string tag;
    @(negedge clk);
    guardBtn = g; actionBtn = a;
    gP = g & ~mPrevG; gR = ~g & mPrevG; aP = a & ~mPrevA;
    pulse = 1'b0;
    tag = "R3";
    case (mState)
      0: begin tag = "R3"; if (gP) mState = 1; end
      1: begin
        if (gR && aP) begin tag = "R6"; mState = 0; end
        else if (gR) begin tag = "R4"; mState = 0; end
        else if (aP) begin tag = "R5"; mState = 2; pulse = 1'b1; end
        else tag = "R4";
      end
      default: begin tag = "R7"; if (gR) mState = 0; end
    endcase
    mPrevG = g; mPrevA = a;
    @(posedge clk);
    #1;
    compare(tag, mState, pulse);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL R1: watchdog actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    bit p;
    int pulses;
    // R1 reset state
    applyReset(1'b0, 1'b0);

    // R2: guard held through reset counts as a press at the first edge
    applyReset(1'b1, 1'b0);
    @(posedge clk); #1;
    checks++;
    if (stateOut !== 2'd1) begin
      fails++;
      $display("FAIL R2: state actual=%0d expected=1", stateOut);
    end
    mState = 1; mPrevG = 1'b1;
    step(1'b1, 1'b0, p);
    step(1'b0, 1'b0, p);

    // R8: repeated action presses during one guard hold
    applyReset(1'b0, 1'b0);
    pulses = 0;
    step(1'b1, 1'b0, p);
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b1, p); if (resetReq) pulses++;
      step(1'b1, 1'b0, p); if (resetReq) pulses++;
    end
    checks++;
    if (pulses != 1) begin
      fails++;
      $display("FAIL R8: pulses actual=%0d expected=1", pulses);
    end
    step(1'b0, 1'b0, p);

    // Exhaustive sweep of five-step level sequences (R3..R7)
    for (int seq = 0; seq < 1024; seq++) begin
      applyReset(1'b0, 1'b0);
      for (int s = 0; s < 5; s++) begin
        step(seq[2*s], seq[2*s+1], p);
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule